// File: doc/BRIEF.md
# Bit-Slice Operand Select and ALU Stage

This block is the purely combinational arithmetic stage of a 4-bit slice processor. It takes the two register-file read ports (A and B), the working register (Q) and the external data bus (D). A 3-bit source code chooses an ordered operand pair (R, S) from them, and some of the pairs put a zero in one slot. A 3-bit function code then picks one of three arithmetic or five logic operations, and a carry-in feeds the arithmetic ones. The slice width is a parameter. Slices can be chained through the carry-out or through the active-low group generate and propagate outputs of a lookahead unit.

Besides the result F, the block reports carry-out, overflow, a zero flag and the sign bit, so a sequencer can branch on them. Register storage and write-back are handled elsewhere.

Top module: `slice_alu`

## Requirements
- R1: Source code values 0..7 select the (R,S) pairs (A,Q), (A,B), (0,Q), (0,B), (0,A), (D,A), (D,Q), (D,0).
- R2: Function code 0 gives F = R + S + cin, modulo 2^W.
- R3: Function code 1 gives F = S + ~R + cin. With cin low this is one less than S minus R.
- R4: Function code 2 gives F = R + ~S + cin.
- R5: Function codes 3, 4 and 5 give R OR S, R AND S and (~R) AND S.
- R6: Function codes 6 and 7 give R XOR S and R XNOR S.
- R7: For function codes 3 to 7, F does not depend on cin.
- R8: The effective operands are (~R,S) for codes 1 and 5, (R,~S) for code 2, and (R,S) for every other code. cout is bit W of effective R + effective S + cin, for every function.
- R9: g_n_o is low exactly when effective R + effective S with cin = 0 carries out of bit W-1. p_n_o is low exactly when every bit of (effective R OR effective S) is one.
- R10: ovf_o is the XOR of the carry into bit W-1 and the carry out of bit W-1 of the effective addition.
- R11: zero_o is high exactly when all bits of F are zero.
- R12: sign_o equals the most significant bit of F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | W | Register-file read port A |
| b_i | input | W | Register-file read port B |
| q_i | input | W | Working register value |
| d_i | input | W | External data input |
| src_i | input | 3 | Operand pair select code |
| fn_i | input | 3 | Function select code |
| cin_i | input | 1 | Carry-in |
| f_o | output | W | Result |
| cout_o | output | 1 | Carry-out of the effective addition |
| g_n_o | output | 1 | Active-low group generate |
| p_n_o | output | 1 | Active-low group propagate |
| ovf_o | output | 1 | Two's-complement overflow |
| zero_o | output | 1 | Result is all zeros |
| sign_o | output | 1 | Result MSB |

## Verification
The checker's assertions are immediate, and each one is valid only while the inputs are settled. They also assume that the source and function codes are always one of the eight defined values. The bench changes the inputs once per cycle, one time unit after the rising edge, and compares the outputs at the falling edge, so every assertion and comparison sees steady values. Every (source, function, carry-in) combination is driven with pseudo-random operands. Directed items cover the carry, overflow, all-ones and all-zeros boundaries.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
  typedef enum logic [2:0] {
    SRC_AQ = 3'd0, SRC_AB = 3'd1, SRC_ZQ = 3'd2, SRC_ZB = 3'd3,
    SRC_ZA = 3'd4, SRC_DA = 3'd5, SRC_DQ = 3'd6, SRC_DZ = 3'd7
  } src_e;

  typedef enum logic [2:0] {
    FN_ADD  = 3'd0, FN_SUBR = 3'd1, FN_SUBS  = 3'd2, FN_OR  = 3'd3,
    FN_AND  = 3'd4, FN_NRAS = 3'd5, FN_XOR   = 3'd6, FN_XNOR = 3'd7
  } fn_e;
endpackage

// File: rtl/slice_opsel.sv
module slice_opsel
  import slice_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] d_i,
  input  logic [2:0]   src_i,
  output logic [W-1:0] r_o,
  output logic [W-1:0] s_o
);
  localparam logic [W-1:0] ZERO = '0;

  always_comb begin
    unique case (src_e'(src_i))
      SRC_AQ:  begin r_o = a_i;  s_o = q_i;  end
      SRC_AB:  begin r_o = a_i;  s_o = b_i;  end
      SRC_ZQ:  begin r_o = ZERO; s_o = q_i;  end
      SRC_ZB:  begin r_o = ZERO; s_o = b_i;  end
      SRC_ZA:  begin r_o = ZERO; s_o = a_i;  end
      SRC_DA:  begin r_o = d_i;  s_o = a_i;  end
      SRC_DQ:  begin r_o = d_i;  s_o = q_i;  end
      default: begin r_o = d_i;  s_o = ZERO; end
    endcase
  end
endmodule

// File: rtl/slice_cla.sv
module slice_cla #(
  parameter int W = 4
) (
  input  logic [W-1:0] re_i,
  input  logic [W-1:0] se_i,
  input  logic         cin_i,
  output logic [W:0]   c_o,
  output logic         g_n_o,
  output logic         p_n_o
);
  logic [W-1:0] gen;
  logic [W-1:0] prp;
  logic [W:0]   grp_g;

  assign gen      = re_i & se_i;
  assign prp      = re_i | se_i;
  assign c_o[0]   = cin_i;
  assign grp_g[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign c_o[i+1]   = gen[i] | (prp[i] & c_o[i]);
    assign grp_g[i+1] = gen[i] | (prp[i] & grp_g[i]);
  end

  assign g_n_o = ~grp_g[W];
  assign p_n_o = ~(&prp);
endmodule

// File: rtl/slice_fcore.sv
module slice_fcore
  import slice_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] re_i,
  input  logic [W-1:0] se_i,
  input  logic [W-1:0] c_i,
  input  logic [2:0]   fn_i,
  output logic [W-1:0] f_o
);
  logic [W-1:0] sum;

  assign sum = re_i ^ se_i ^ c_i;

  always_comb begin
    unique case (fn_e'(fn_i))
      FN_ADD, FN_SUBR, FN_SUBS: f_o = sum;
      FN_OR:   f_o = r_i | s_i;
      FN_AND:  f_o = r_i & s_i;
      FN_NRAS: f_o = ~r_i & s_i;
      FN_XOR:  f_o = r_i ^ s_i;
      default: f_o = ~(r_i ^ s_i);
    endcase
  end
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] d_i,
  input  logic [2:0]   src_i,
  input  logic [2:0]   fn_i,
  input  logic         cin_i,
  output logic [W-1:0] f_o,
  output logic         cout_o,
  output logic         g_n_o,
  output logic         p_n_o,
  output logic         ovf_o,
  output logic         zero_o,
  output logic         sign_o
);
  logic [W-1:0] r, s, re, se;
  logic [W:0]   c;
  logic         inv_r, inv_s;

  slice_opsel #(.W(W)) u_opsel (
    .a_i(a_i), .b_i(b_i), .q_i(q_i), .d_i(d_i), .src_i(src_i),
    .r_o(r), .s_o(s)
  );

  assign inv_r = (fn_i == FN_SUBR) || (fn_i == FN_NRAS);
  assign inv_s = (fn_i == FN_SUBS);
  assign re    = inv_r ? ~r : r;
  assign se    = inv_s ? ~s : s;

  slice_cla #(.W(W)) u_cla (
    .re_i(re), .se_i(se), .cin_i(cin_i),
    .c_o(c), .g_n_o(g_n_o), .p_n_o(p_n_o)
  );

  slice_fcore #(.W(W)) u_fcore (
    .r_i(r), .s_i(s), .re_i(re), .se_i(se), .c_i(c[W-1:0]),
    .fn_i(fn_i), .f_o(f_o)
  );

  assign cout_o = c[W];
  assign ovf_o  = c[W] ^ c[W-1];
  assign zero_o = ~(|f_o);
  assign sign_o = f_o[W-1];
endmodule

// File: rtl/slice_alu_chk.sv
module slice_alu_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic [W-1:0] q_i,
  input logic [W-1:0] d_i,
  input logic [2:0]   src_i,
  input logic [2:0]   fn_i,
  input logic         cin_i,
  input logic [W-1:0] f_o,
  input logic         cout_o,
  input logic         g_n_o,
  input logic         p_n_o,
  input logic         ovf_o,
  input logic         zero_o,
  input logic         sign_o
);
  always_comb begin
    AST_GEN_CARRY: assert (g_n_o || cout_o);  // R9
    AST_PROP_CARRY: assert (p_n_o || !cin_i || cout_o);  // R9
    AST_ADD_OVF: assert (!(fn_i == 3'd0 && src_i == 3'd1) ||
                         (ovf_o == ((a_i[W-1] == b_i[W-1]) && (sign_o != a_i[W-1]))));  // R10
    AST_XOR_ZERO: assert (!(fn_i == 3'd6 && src_i == 3'd1) || (zero_o == (a_i == b_i)));  // R11
    AST_ADD_DZ: assert (!(fn_i == 3'd0 && src_i == 3'd7) ||
                        (f_o == d_i + {{(W-1){1'b0}}, cin_i}));  // R2
    AST_AND_ZR: assert (!(fn_i == 3'd4 && (src_i == 3'd2 || src_i == 3'd3 || src_i == 3'd4)) ||
                        zero_o);  // R5
    AST_OR_ZQ: assert (!(fn_i == 3'd3 && src_i == 3'd2) || (f_o == q_i));  // R1
  end
endmodule

bind slice_alu slice_alu_chk #(.W(W)) u_chk (.*);

// File: tb/test_slice_alu.sv
module test_slice_alu;
  localparam int W = 4;
  localparam int M = (1 << W) - 1;

  typedef struct {
    logic [W-1:0] f;
    logic cout, g_n, p_n, ovf, zero, sign;
    string ftag;
  } exp_t;

  logic clk, rst_n;
  logic [W-1:0] a, b, q, d;
  logic [2:0] src, fn;
  logic cin;
  logic [W-1:0] f;
  logic cout, g_n, p_n, ovf, zero, sign;

  int total = 0;
  int bad = 0;
  exp_t sb[$];

  slice_alu #(.W(W)) i_slice_alu (
    .a_i(a), .b_i(b), .q_i(q), .d_i(d), .src_i(src), .fn_i(fn), .cin_i(cin),
    .f_o(f), .cout_o(cout), .g_n_o(g_n), .p_n_o(p_n), .ovf_o(ovf),
    .zero_o(zero), .sign_o(sign)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input int va, input int vb, input int vq, input int vd,
                       input int vsrc, input int vfn, input int vcin, input string tag);
    int r, s, re, se, fv, sum, lo;
    exp_t e;
    @(posedge clk);
    #1;
    a = va[W-1:0]; b = vb[W-1:0]; q = vq[W-1:0]; d = vd[W-1:0];
    src = vsrc[2:0]; fn = vfn[2:0]; cin = vcin[0];
    case (vsrc)
      0: begin r = va; s = vq; end
      1: begin r = va; s = vb; end
      2: begin r = 0;  s = vq; end
      3: begin r = 0;  s = vb; end
      4: begin r = 0;  s = va; end
      5: begin r = vd; s = va; end
      6: begin r = vd; s = vq; end
      default: begin r = vd; s = 0; end
    endcase
    re = (vfn == 1 || vfn == 5) ? (M - r) : r;
    se = (vfn == 2) ? (M - s) : s;
    sum = re + se + vcin;
    case (vfn)
      0, 1, 2: fv = sum & M;
      3: fv = r | s;
      4: fv = r & s;
      5: fv = (M - r) & s;
      6: fv = r ^ s;
      default: fv = M - (r ^ s);
    endcase
    lo = ((re & (M >> 1)) + (se & (M >> 1)) + vcin) >> (W - 1);
    e.f    = fv[W-1:0];
    e.cout = (sum >> W) & 1;
    e.g_n  = !(((re + se) >> W) & 1);
    e.p_n  = !((re | se) == M);
    e.ovf  = (lo & 1) != ((sum >> W) & 1);
    e.zero = (fv == 0);
    e.sign = (fv >> (W - 1)) & 1;
    if (tag != "") e.ftag = tag;
    else case (vfn)
      0: e.ftag = "R2";
      1: e.ftag = "R3";
      2: e.ftag = "R4";
      3, 4, 5: e.ftag = (vcin != 0) ? "R7" : "R5";
      default: e.ftag = (vcin != 0) ? "R7" : "R6";
    endcase
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.ftag, " f"}, int'(f), int'(e.f));
      chk("R8 cout", int'(cout), int'(e.cout));
      chk("R9 g_n", int'(g_n), int'(e.g_n));
      chk("R9 p_n", int'(p_n), int'(e.p_n));
      chk("R10 ovf", int'(ovf), int'(e.ovf));
      chk("R11 zero", int'(zero), int'(e.zero));
      chk("R12 sign", int'(sign), int'(e.sign));
    end
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lfsr;
    a = '0; b = '0; q = '0; d = '0; src = '0; fn = '0; cin = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // all-zero inputs: sum is zero, zero flag set
    drive(0, 0, 0, 0, 0, 0, 0, "R2");
    // R1: each source code with distinct operands, through OR and XOR
    for (int sc = 0; sc < 8; sc++) begin
      drive(1, 2, 4, 8, sc, 3, 0, "R1");
      drive(3, 5, 6, 9, sc, 6, 0, "R1");
    end
    // R3 boundary: equal operands with cin low give all ones
    drive(5, 0, 5, 0, 0, 1, 0, "R3");
    drive(5, 0, 5, 0, 0, 1, 1, "R3");
    // R4 boundary
    drive(3, 7, 0, 0, 1, 2, 1, "R4");
    // R10: positive overflow and negative overflow
    drive(7, 1, 0, 0, 1, 0, 0, "R10");
    drive(8, 8, 0, 0, 1, 0, 0, "R10");
    // R8, R9: all-ones plus carry wraps through propagate
    drive(15, 0, 0, 0, 0, 0, 1, "R8");
    drive(15, 15, 0, 0, 1, 0, 0, "R9");
    // R11: xor of equal values
    drive(9, 9, 0, 0, 1, 6, 0, "R11");
    // R7: logic functions with both carry states
    for (int fc = 3; fc < 8; fc++) begin
      drive(12, 10, 0, 0, 1, fc, 0, "");
      drive(12, 10, 0, 0, 1, fc, 1, "");
    end
    // sweep every source/function/carry with pseudo-random operands
    lfsr = 16'hACE1;
    for (int sc = 0; sc < 8; sc++)
      for (int fc = 0; fc < 8; fc++)
        for (int ci = 0; ci < 2; ci++)
          for (int k = 0; k < 12; k++) begin
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0)) & 16'hFFFF;
            drive(lfsr & M, (lfsr >> 4) & M, (lfsr >> 8) & M, (lfsr >> 12) & M,
                  sc, fc, ci, "");
          end
    repeat (3) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule